// File: doc/BRIEF.md
# USB Host Outbound Packet Prefill Scheduler

This block decides whether, and when, a USB host controller may put an outbound OUT or SETUP packet on the bus inside the current frame or microframe. A countdown register tracks the time left before the next start-of-frame. It is measured in overhead units: one unit lasts 1.267 us at high speed and 6.333 us at full or low speed. The countdown reloads on every start-of-frame pulse and drops by one on every unit tick. A pending packet comes with an estimated bus time. That estimate plus a programmable overhead forms the time budget the packet needs.

When the budget fits, the scheduler requests data bursts into the transmit latency FIFO. It raises a packet-start strobe once enough bursts are buffered. If the remaining time drops below the budget while the FIFO is still filling, the attempt is abandoned as a back-off. The scheduler then asks for the partial data to be flushed, so that periodic traffic after the next start-of-frame has room. It does not begin another fill until that flush is acknowledged. A 5-bit saturating counter records back-off events so that software can tune the burst threshold and the overhead.

Configuration lives in one 32-bit word. Writing the word sets the threshold and overhead fields and clears the back-off counter.

Top module: `usb_tx_prefill_sched`

## Requirements
- R1: After reset the configuration word reads 0x0000_0002 and burst_req, pkt_start, backoff and fifo_flush are all low.
- R2: The configuration word holds the burst threshold in bits 7:0, the back-off count in bits 12:8 and the overhead in bits 21:16. All other bits read as zero. A write stores bits 7:0 and 21:16 and ignores every other written bit.
- R3: A sof_pulse reloads the remaining-time count to 98 units when speed_hs is 1 and to 157 units when it is 0. Each unit_tick without sof_pulse lowers the count by one. The count stops at 0, and sof_pulse wins over a simultaneous tick.
- R4: An idle scheduler with pkt_req high starts a fill (burst_req high on the next cycle) only when the remaining count is at least pkt_time plus the overhead. Otherwise it requests nothing and raises no strobe.
- R5: The fill target is the burst threshold raised to at least 2 and capped at pkt_bursts (at least 1). Exactly that many burst_ack pulses are requested before the packet starts.
- R6: When stream_off is 1 the burst threshold is ignored, and the fill target is pkt_bursts.
- R7: pkt_start is a one-cycle strobe in the cycle after the target count is reached with time still within budget. A new attempt begins only after pkt_req has been low.
- R8: During a fill, a remaining count below the budget gives a one-cycle backoff strobe and no pkt_start for that attempt. pkt_start and backoff are never high together.
- R9: fifo_flush is high from the back-off cycle until a flush_ack arrives in a later cycle. burst_req stays low throughout, and a new fill can start only after the acknowledge.
- R10: The back-off count rises by one per back-off event and holds at 31.
- R11: Any write to the configuration word clears the back-off count, and a write in the same cycle as a back-off leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| sof_pulse | input | 1 | Start-of-frame pulse, reloads the time count |
| unit_tick | input | 1 | One pulse per overhead time unit |
| speed_hs | input | 1 | 1 selects high-speed unit and frame length |
| stream_off | input | 1 | 1 fills the whole packet before start |
| pkt_req | input | 1 | An outbound packet is pending |
| pkt_time | input | 8 | Estimated packet bus time in units |
| pkt_bursts | input | 8 | Number of data bursts in the packet |
| burst_req | output | 1 | Request for one burst into the latency FIFO |
| burst_ack | input | 1 | One burst has been posted |
| pkt_start | output | 1 | Strobe: start the packet on the bus |
| backoff | output | 1 | Strobe: attempt abandoned for lack of time |
| fifo_flush | output | 1 | Discard partial packet data in the FIFO |
| flush_ack | input | 1 | Flush finished |

## Verification
The bench goes after the exact edges of the time budget. It tests a remaining count equal to the budget and one unit short, at both speeds, and a count held at zero. An off-by-one or a countdown that wraps would turn a start into a skip or the reverse. It tests thresholds below the minimum, above the packet length and under stream-off. A wrong clamp shows up there as a wrong number of requested bursts. It provokes back-offs both at the first fill cycle and after a partial fill, and holds pkt_req high across a flush. A design that let the back-off and start strobes collide, or that refilled before the flush finished, would raise the wrong strobe or an early burst_req. The bench also drives the counter past 31 and clears it on the very cycle of a back-off, which exposes wrap-around and a wrong write priority.

// File: rtl/usb_txp_pkg.sv
`timescale 1ns/1ps
package usb_txp_pkg;
  localparam int CFG_W    = 32;
  localparam int THR_W    = 8;
  localparam int THR_LSB  = 0;
  localparam int THR_RST  = 2;
  localparam int THR_MIN  = 2;
  localparam int HLT_W    = 5;
  localparam int HLT_LSB  = 8;
  localparam int OVH_W    = 6;
  localparam int OVH_LSB  = 16;
  localparam int HLT_MAX  = (1 << HLT_W) - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_START,
    ST_DONE,
    ST_BACKOFF,
    ST_FLUSH
  } sched_st_e;
endpackage

// File: rtl/usb_txp_regs.sv
`timescale 1ns/1ps
module usb_txp_regs
  import usb_txp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             backoff_evt,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [THR_W-1:0] thr_o,
  output logic [OVH_W-1:0] ovh_o
);
  localparam logic [HLT_W-1:0] HLT_TOP = HLT_W'(HLT_MAX);

  logic [THR_W-1:0] thr_q, thr_d;
  logic [OVH_W-1:0] ovh_q, ovh_d;
  logic [HLT_W-1:0] hlt_q, hlt_d;
  logic             hlt_en;
  logic             unused_wbits;

  assign unused_wbits = ^{cfg_wdata[CFG_W-1:OVH_LSB+OVH_W],
                          cfg_wdata[OVH_LSB-1:THR_LSB+THR_W]};

  always_comb begin
    thr_d  = cfg_wdata[THR_LSB +: THR_W];
    ovh_d  = cfg_wdata[OVH_LSB +: OVH_W];
    hlt_en = cfg_we | (backoff_evt & (hlt_q != HLT_TOP));
    if (cfg_we) hlt_d = '0;
    else        hlt_d = hlt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= THR_W'(THR_RST);
      ovh_q <= '0;
    end else if (cfg_we) begin
      thr_q <= thr_d;
      ovh_q <= ovh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     hlt_q <= '0;
    else if (hlt_en) hlt_q <= hlt_d;
  end

  always_comb begin
    cfg_rdata                      = '0;
    cfg_rdata[THR_LSB +: THR_W]    = thr_q;
    cfg_rdata[HLT_LSB +: HLT_W]    = hlt_q;
    cfg_rdata[OVH_LSB +: OVH_W]    = ovh_q;
  end

  assign thr_o = thr_q;
  assign ovh_o = ovh_q;

  // R10
  hlt_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (backoff_evt && !cfg_we && hlt_q != HLT_TOP) |=> hlt_q == $past(hlt_q) + 1'b1);
  // R10
  hlt_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hlt_q == HLT_TOP && !cfg_we) |=> hlt_q == HLT_TOP);
  // R11
  hlt_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_we |=> hlt_q == '0);
endmodule

// File: rtl/usb_txp_frame_timer.sv
`timescale 1ns/1ps
module usb_txp_frame_timer #(
  parameter int HS_LEN = 98,
  parameter int FS_LEN = 157,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             sof,
  input  logic             tick,
  input  logic             speed_hs,
  output logic [CNT_W-1:0] remain_o
);
  localparam logic [CNT_W-1:0] HS_RLD = CNT_W'(HS_LEN);
  localparam logic [CNT_W-1:0] FS_RLD = CNT_W'(FS_LEN);

  logic [CNT_W-1:0] remain_q, remain_d;
  logic             remain_en;

  always_comb begin
    remain_en = sof | (tick & (remain_q != '0));
    if (sof) remain_d = speed_hs ? HS_RLD : FS_RLD;
    else     remain_d = remain_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        remain_q <= '0;
    else if (remain_en) remain_q <= remain_d;
  end

  assign remain_o = remain_q;

  // R3
  reload_len_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sof |=> remain_q == ($past(speed_hs) ? HS_RLD : FS_RLD));
  // R3
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !sof && remain_q != '0) |=> remain_q == $past(remain_q) - 1'b1);
  // R3
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!sof && remain_q == '0) |=> remain_q == '0);
endmodule

// File: rtl/usb_txp_fsm.sv
`timescale 1ns/1ps
module usb_txp_fsm
  import usb_txp_pkg::*;
#(
  parameter int PT_W  = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             pkt_req,
  input  logic [PT_W-1:0]  pkt_time,
  input  logic [THR_W-1:0] pkt_bursts,
  input  logic             stream_off,
  input  logic [THR_W-1:0] thr,
  input  logic [OVH_W-1:0] ovh,
  input  logic [CNT_W-1:0] remain,
  input  logic             burst_ack,
  input  logic             flush_ack,
  output logic             burst_req,
  output logic             pkt_start,
  output logic             backoff,
  output logic             fifo_flush
);
  localparam int BUD_W = ((PT_W > OVH_W) ? PT_W : OVH_W) + 1;
  localparam int CMP_W = (BUD_W > CNT_W) ? BUD_W : CNT_W;

  sched_st_e        st_q, st_d;
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [THR_W-1:0] thr_eff, tgt_raw, tgt;
  logic [CMP_W-1:0] budget;
  logic             time_ok;
  logic             tgt_hit;

  always_comb begin
    budget  = CMP_W'(pkt_time) + CMP_W'(ovh);
    time_ok = CMP_W'(remain) >= budget;
  end

  always_comb begin
    thr_eff = (thr < THR_W'(THR_MIN)) ? THR_W'(THR_MIN) : thr;
    if (stream_off)              tgt_raw = pkt_bursts;
    else if (thr_eff > pkt_bursts) tgt_raw = pkt_bursts;
    else                         tgt_raw = thr_eff;
    tgt     = (tgt_raw == '0) ? THR_W'(1) : tgt_raw;
    tgt_hit = (cnt_q >= tgt);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (pkt_req && time_ok) st_d = ST_FILL;
      ST_FILL: begin
        if (!time_ok)     st_d = ST_BACKOFF;
        else if (tgt_hit) st_d = ST_START;
      end
      ST_START:   st_d = ST_DONE;
      ST_DONE:    if (!pkt_req) st_d = ST_IDLE;
      ST_BACKOFF: st_d = ST_FLUSH;
      ST_FLUSH:   if (flush_ack) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (st_q == ST_IDLE) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (st_q == ST_FILL && burst_ack && !tgt_hit) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign burst_req  = (st_q == ST_FILL) && !tgt_hit;
  assign pkt_start  = (st_q == ST_START);
  assign backoff    = (st_q == ST_BACKOFF);
  assign fifo_flush = (st_q == ST_BACKOFF) || (st_q == ST_FLUSH);

  // R4
  fill_admit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(burst_req) |-> $past(st_q == ST_IDLE && pkt_req && time_ok));
  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pkt_start |-> $past(st_q == ST_FILL && time_ok && tgt_hit));
  // R8
  backoff_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    backoff |-> $past(st_q == ST_FILL && !time_ok));
  // R8
  backoff_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    backoff |=> (!backoff && !pkt_start && fifo_flush));
  // R9
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (fifo_flush && !backoff && !flush_ack) |=> (fifo_flush && !burst_req));
endmodule

// File: rtl/usb_tx_prefill_sched.sv
`timescale 1ns/1ps
module usb_tx_prefill_sched
  import usb_txp_pkg::*;
#(
  parameter int PT_W           = 8,
  parameter int HS_FRAME_UNITS = 98,
  parameter int FS_FRAME_UNITS = 157
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             sof_pulse,
  input  logic             unit_tick,
  input  logic             speed_hs,
  input  logic             stream_off,
  input  logic             pkt_req,
  input  logic [PT_W-1:0]  pkt_time,
  input  logic [THR_W-1:0] pkt_bursts,
  output logic             burst_req,
  input  logic             burst_ack,
  output logic             pkt_start,
  output logic             backoff,
  output logic             fifo_flush,
  input  logic             flush_ack
);
  localparam int FRAME_MAX = (HS_FRAME_UNITS > FS_FRAME_UNITS) ? HS_FRAME_UNITS : FS_FRAME_UNITS;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [THR_W-1:0] thr;
  logic [OVH_W-1:0] ovh;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  usb_txp_regs u_regs (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .backoff_evt (backoff),
    .cfg_rdata   (cfg_rdata),
    .thr_o       (thr),
    .ovh_o       (ovh)
  );

  usb_txp_frame_timer #(
    .HS_LEN (HS_FRAME_UNITS),
    .FS_LEN (FS_FRAME_UNITS),
    .CNT_W  (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .sof      (sof_pulse),
    .tick     (unit_tick),
    .speed_hs (speed_hs),
    .remain_o (remain)
  );

  usb_txp_fsm #(
    .PT_W  (PT_W),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .pkt_req    (pkt_req),
    .pkt_time   (pkt_time),
    .pkt_bursts (pkt_bursts),
    .stream_off (stream_off),
    .thr        (thr),
    .ovh        (ovh),
    .remain     (remain),
    .burst_ack  (burst_ack),
    .flush_ack  (flush_ack),
    .burst_req  (burst_req),
    .pkt_start  (pkt_start),
    .backoff    (backoff),
    .fifo_flush (fifo_flush)
  );

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(pkt_start && backoff));
endmodule

// File: tb/tb_usb_tx_prefill_sched.sv
`timescale 1ns/1ps
module tb_usb_tx_prefill_sched;
  localparam logic [1:0] OC_SKIP  = 2'd0;
  localparam logic [1:0] OC_START = 2'd1;
  localparam logic [1:0] OC_BACK  = 2'd2;

  typedef struct packed {
    logic [7:0] thr;
    logic [5:0] ovh;
    logic       soff;
    logic       hs;
    logic [7:0] ptime;
    logic [7:0] pb;
    logic [7:0] pre;
    logic       tf;
    logic [1:0] exp;
    logic [7:0] eb;
  } vec_t;

  // thr, ovh, stream_off, speed_hs, pkt_time, pkt_bursts, pre-ticks, tick-during-fill, outcome, bursts
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 6'd0,  1'b0, 1'b1, 8'd10,  8'd8, 8'd0,   1'b0, 2'd1, 8'd2},  // R5 minimum threshold
    '{8'd5, 6'd4,  1'b0, 1'b1, 8'd20,  8'd8, 8'd50,  1'b0, 2'd1, 8'd5},  // R5
    '{8'd0, 6'd0,  1'b0, 1'b1, 8'd10,  8'd8, 8'd0,   1'b0, 2'd1, 8'd2},  // R5 raised to 2
    '{8'd6, 6'd0,  1'b1, 1'b1, 8'd10,  8'd3, 8'd0,   1'b0, 2'd1, 8'd3},  // R6
    '{8'd2, 6'd0,  1'b1, 1'b1, 8'd10,  8'd5, 8'd0,   1'b0, 2'd1, 8'd5},  // R6
    '{8'd9, 6'd0,  1'b0, 1'b1, 8'd10,  8'd4, 8'd0,   1'b0, 2'd1, 8'd4},  // R5 capped
    '{8'd2, 6'd10, 1'b0, 1'b1, 8'd30,  8'd8, 8'd60,  1'b0, 2'd0, 8'd0},  // R4 overhead blocks
    '{8'd2, 6'd0,  1'b0, 1'b1, 8'd30,  8'd8, 8'd60,  1'b0, 2'd1, 8'd2},  // R4
    '{8'd2, 6'd7,  1'b0, 1'b0, 8'd30,  8'd8, 8'd120, 1'b0, 2'd1, 8'd2},  // R3 full speed
    '{8'd2, 6'd0,  1'b0, 1'b1, 8'd98,  8'd8, 8'd0,   1'b0, 2'd1, 8'd2},  // R3 HS edge
    '{8'd2, 6'd0,  1'b0, 1'b1, 8'd99,  8'd8, 8'd0,   1'b0, 2'd0, 8'd0},  // R3 HS one short
    '{8'd2, 6'd8,  1'b0, 1'b0, 8'd150, 8'd8, 8'd0,   1'b0, 2'd0, 8'd0},  // R3 FS one short
    '{8'd2, 6'd7,  1'b0, 1'b0, 8'd150, 8'd8, 8'd0,   1'b0, 2'd1, 8'd2},  // R3 FS edge
    '{8'd2, 6'd0,  1'b0, 1'b1, 8'd0,   8'd8, 8'd200, 1'b0, 2'd1, 8'd2},  // R3 floor at 0
    '{8'd2, 6'd8,  1'b0, 1'b1, 8'd40,  8'd8, 8'd50,  1'b1, 2'd2, 8'd0},  // R8 no margin
    '{8'd2, 6'd8,  1'b0, 1'b1, 8'd40,  8'd8, 8'd47,  1'b1, 2'd1, 8'd2},  // R8 margin suffices
    '{8'd4, 6'd8,  1'b0, 1'b1, 8'd40,  8'd8, 8'd47,  1'b1, 2'd2, 8'd0}   // R8 partial fill
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        sof_pulse, unit_tick, speed_hs, stream_off, pkt_req;
  logic [7:0]  pkt_time, pkt_bursts;
  logic        burst_req, burst_ack, pkt_start, backoff, fifo_flush, flush_ack;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  usb_tx_prefill_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sof_pulse(sof_pulse), .unit_tick(unit_tick), .speed_hs(speed_hs), .stream_off(stream_off),
    .pkt_req(pkt_req), .pkt_time(pkt_time), .pkt_bursts(pkt_bursts), .burst_req(burst_req),
    .burst_ack(burst_ack), .pkt_start(pkt_start), .backoff(backoff), .fifo_flush(fifo_flush),
    .flush_ack(flush_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] d);
    cfg_we = 1'b1;
    cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic frame_start(input logic hs, input int pre);
    speed_hs = hs;
    sof_pulse = 1'b1;
    cyc();
    sof_pulse = 1'b0;
    for (int i = 0; i < pre; i++) begin
      unit_tick = 1'b1;
      cyc();
    end
    unit_tick = 1'b0;
  endtask

  task automatic attempt(input logic tf, input int maxc, output logic [1:0] oc, output int nb);
    oc = OC_SKIP;
    nb = 0;
    pkt_req = 1'b1;
    unit_tick = tf;
    burst_ack = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      cyc();
      if (pkt_start) begin oc = OC_START; break; end
      if (backoff)   begin oc = OC_BACK;  break; end
      burst_ack = burst_req;
      if (burst_req) nb++;
    end
    burst_ack = 1'b0;
    unit_tick = 1'b0;
  endtask

  task automatic backoff_once(input bit clr_same);
    logic [1:0] oc;
    int nb;
    pkt_time = 8'd40; pkt_bursts = 8'd8; stream_off = 1'b0;
    frame_start(1'b1, 50);
    attempt(1'b1, 40, oc, nb);
    chk(oc == OC_BACK, "R8 forced back-off", 32'(oc), 32'(OC_BACK));
    if (clr_same) begin
      cfg_we = 1'b1;
      cfg_wdata = 32'h0008_0002;
    end
    pkt_req = 1'b0;
    cyc();
    cfg_we = 1'b0;
    flush_ack = 1'b1;
    cyc();
    flush_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog R7 run did not complete actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] oc;
    int nb;
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0; sof_pulse = 1'b0; unit_tick = 1'b0; speed_hs = 1'b1;
    stream_off = 1'b0; pkt_req = 1'b0; pkt_time = '0; pkt_bursts = 8'd8;
    burst_ack = 1'b0; flush_ack = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    chk(cfg_rdata == 32'h0000_0002, "R1 cfg reset", cfg_rdata, 32'h0000_0002);
    chk({burst_req, pkt_start, backoff, fifo_flush} == 4'b0, "R1 outputs idle",
        32'({burst_req, pkt_start, backoff, fifo_flush}), 32'h0);

    // R2 layout: reserved bits read zero
    write_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h003F_00FF, "R2 layout all ones", cfg_rdata, 32'h003F_00FF);
    write_cfg(32'h0000_0000);
    chk(cfg_rdata == 32'h0000_0000, "R2 layout zeros", cfg_rdata, 32'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      write_cfg({10'd0, VECS[v].ovh, 8'd0, VECS[v].thr});
      stream_off = VECS[v].soff;
      pkt_time   = VECS[v].ptime;
      pkt_bursts = VECS[v].pb;
      frame_start(VECS[v].hs, int'(VECS[v].pre));
      attempt(VECS[v].tf, 40, oc, nb);
      chk(oc == VECS[v].exp, $sformatf("R4 R5 R6 R8 outcome vec %0d", v), 32'(oc), 32'(VECS[v].exp));
      if (VECS[v].exp != OC_BACK)
        chk(nb == int'(VECS[v].eb), $sformatf("R5 R6 burst count vec %0d", v), 32'(nb), 32'(VECS[v].eb));
      if (oc == OC_START) begin
        pkt_req = 1'b0;
        cyc();
        chk(pkt_start == 1'b0, $sformatf("R7 single strobe vec %0d", v), 32'(pkt_start), 32'h0);
        cyc();
      end else if (oc == OC_BACK) begin
        chk(fifo_flush == 1'b1 && pkt_start == 1'b0, $sformatf("R8 R9 flush at back-off vec %0d", v),
            32'({fifo_flush, pkt_start}), 32'h2);
        pkt_req = 1'b0;
        cyc();
        flush_ack = 1'b1;
        cyc();
        flush_ack = 1'b0;
      end else begin
        pkt_req = 1'b0;
        cyc();
      end
      chk(cfg_rdata[12:8] == ((VECS[v].exp == OC_BACK) ? 5'd1 : 5'd0),
          $sformatf("R10 count vec %0d", v), 32'(cfg_rdata[12:8]),
          (VECS[v].exp == OC_BACK) ? 32'd1 : 32'd0);
    end

    // R9 no refill while the flush is outstanding
    write_cfg(32'h0008_0002);
    pkt_time = 8'd40; pkt_bursts = 8'd8; stream_off = 1'b0;
    frame_start(1'b1, 50);
    attempt(1'b1, 40, oc, nb);
    chk(oc == OC_BACK, "R9 back-off setup", 32'(oc), 32'(OC_BACK));
    pkt_req = 1'b1;
    sof_pulse = 1'b1;
    cyc();
    sof_pulse = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(fifo_flush == 1'b1 && burst_req == 1'b0, "R9 flush holds fill off",
          32'({fifo_flush, burst_req}), 32'h2);
      cyc();
    end
    flush_ack = 1'b1;
    cyc();
    flush_ack = 1'b0;
    chk(fifo_flush == 1'b0 && burst_req == 1'b0, "R9 idle after ack",
        32'({fifo_flush, burst_req}), 32'h0);
    cyc();
    chk(burst_req == 1'b1, "R9 refill after ack", 32'(burst_req), 32'h1);
    burst_ack = 1'b1;
    cyc();
    cyc();
    burst_ack = 1'b0;
    cyc();
    chk(pkt_start == 1'b1, "R7 start after refill", 32'(pkt_start), 32'h1);
    pkt_req = 1'b0;
    cyc();
    cyc();

    // R10 saturation
    write_cfg(32'h0008_0002);
    for (int k = 0; k < 33; k++) backoff_once(1'b0);
    chk(cfg_rdata[12:8] == 5'd31, "R10 saturates at 31", 32'(cfg_rdata[12:8]), 32'd31);

    // R11 write clears
    write_cfg(32'h0008_0002);
    chk(cfg_rdata[12:8] == 5'd0, "R11 write clears", 32'(cfg_rdata[12:8]), 32'd0);
    backoff_once(1'b0);
    chk(cfg_rdata[12:8] == 5'd1, "R10 one event", 32'(cfg_rdata[12:8]), 32'd1);
    backoff_once(1'b1);
    chk(cfg_rdata[12:8] == 5'd0, "R11 write wins over back-off", 32'(cfg_rdata[12:8]), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule